// File: doc/BRIEF.md
# Serial Infrared Pulse Transmitter

This block sends bytes over an infrared link at the slow serial rates (2400 up to 115200 baud). Each byte is framed as an asynchronous character: one start bit, eight data bits with the least significant bit first, and one stop bit. A bit of value zero is sent as a short light pulse that begins at the start of that bit. A bit of value one is sent as no pulse. The line is a single output. A polarity input can invert it.

Timing comes from a pulse clock enable that the block makes by dividing its system clock by five, which gives 8 MHz from 40 MHz. A fractional accumulator turns that enable into the base 115.2 kbaud interval. A 16-bit control word picks the rate and the pulse width. Bits [15:10] hold the rate divisor: the bit period is (divisor+1) base intervals. Bits [9:5] hold the width code: a pulse lasts (code+1)·(divisor+1) enable ticks. Code 12 gives the nominal 3/16 of a bit, and smaller codes give a pulse of about 1.5 µs. Bits [4:0] are a preamble field that has no meaning here. Bytes enter through a valid/ready handshake.

Top module: `sir_tx_modulator`

## Requirements
- R1: While reset is held and after it is released, with no byte offered, `byte_ready` is 1 and `ir_out` is 0 (inversion off).
- R2: `byte_ready` is 1 only while idle, or in the one cycle in which the stop bit of the current byte ends. A byte is taken on a rising edge where `byte_valid` and `byte_ready` are both 1.
- R3: Each byte is sent as a start bit (0), then data bits 0 through 7, then a stop bit (1). Every zero bit gives exactly one pulse and every one bit gives none, so a byte gives (1 + number of zero data bits) pulses.
- R4: The pulse clock enable fires every 5 clocks, counted from the edge that takes a byte out of idle. Bit k (k = 0 for the start bit) begins ceil(625·k·(D+1)/9) enable ticks after that edge, which is 5 times that many clocks. D is control bits [15:10].
- R5: A pulse goes active on the edge where its bit begins and stays active for (W+1)·(D+1) enable ticks, which is 5·(W+1)·(D+1) clocks. W is control bits [9:5]. The pulse is cut short so that it ends before the next bit starts.
- R6: The active level of `ir_out` is 1 and the idle level is 0. When `tx_invert` is 1 both levels are swapped, one clock after `tx_invert` is sampled.
- R7: Control bits [4:0] have no effect on `ir_out` or `byte_ready`.
- R8: The divisor and width fields are captured on the edge that takes a byte. Changing `phy_ctl` while that byte is being sent does not change its waveform.
- R9: A byte offered before the current stop bit ends is taken on that stop-bit boundary. Its start-bit pulse begins on the same edge, with no idle gap, and the bit timing continues without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (40 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_ctl | input | 16 | Rate divisor [15:10], width code [9:5], preamble field [4:0] (unused) |
| tx_invert | input | 1 | Swaps the active and idle levels of the output |
| byte_valid | input | 1 | A byte is offered on byte_data |
| byte_data | input | 8 | Byte to send, sent least significant bit first |
| byte_ready | output | 1 | The block takes the offered byte on this edge |
| ir_out | output | 1 | Infrared pulse line |

## Verification
Two things can happen in the same clock edge: the end of the stop bit of one byte, and the taking of the next byte together with the start of its pulse. The bench provokes this by holding `byte_valid` high with a second byte for the whole first frame. It then checks that `byte_ready` rises only in the cycle just before the boundary edge, and that the second start pulse starts on that exact edge. The output is compared cycle by cycle against a timeline of bit boundaries from a closed-form model. At such a boundary the enable tick is also due, so the check also shows that the newly loaded pulse ignores that tick and keeps its full width.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int BAUD_W  = 6;
  localparam int PW_W    = 5;
  localparam int PRE_W   = 5;
  localparam int CTL_W   = BAUD_W + PW_W + PRE_W;
  localparam int LEN_W   = 14;

  typedef struct packed {
    logic [BAUD_W-1:0] baud;
    logic [PW_W-1:0]   width;
    logic [PRE_W-1:0]  pre;
  } phy_word_t;

  typedef enum logic {ST_IDLE, ST_SEND} tx_state_t;

  // Pulse length in enable ticks, limited to end before the shortest bit.
  function automatic logic [LEN_W-1:0] pulse_len(input logic [BAUD_W-1:0] baud,
                                                 input logic [PW_W-1:0]   wid,
                                                 input int unsigned       base_floor);
    int unsigned raw;
    int unsigned lim;
    raw = (32'(wid) + 32'd1) * (32'(baud) + 32'd1);
    lim = base_floor * (32'(baud) + 32'd1) - 32'd1;
    return LEN_W'((raw < lim) ? raw : lim);
  endfunction
endpackage

// File: rtl/sir_tick_gen.sv
module sir_tick_gen
  import sir_pkg::*;
#(
  parameter int CLK_DIV  = 5,
  parameter int RATE_NUM = 9,
  parameter int RATE_DEN = 625
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BAUD_W-1:0] baud,
  output logic              tick,
  output logic              bit_edge
);
  localparam int PC_W  = $clog2(CLK_DIV);
  localparam int ACC_W = $clog2(RATE_DEN + RATE_NUM);

  logic [PC_W-1:0]   pre_q;
  logic [ACC_W-1:0]  acc_q;
  logic [BAUD_W-1:0] bcnt_q;
  logic [ACC_W:0]    acc_sum;
  logic              base_evt;

  assign acc_sum  = {1'b0, acc_q} + (ACC_W+1)'(RATE_NUM);
  assign tick     = run && (pre_q == PC_W'(CLK_DIV - 1));
  assign base_evt = tick && (acc_sum >= (ACC_W+1)'(RATE_DEN));
  assign bit_edge = base_evt && (bcnt_q == baud);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q  <= '0;
      acc_q  <= '0;
      bcnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        acc_q <= base_evt ? ACC_W'(acc_sum - (ACC_W+1)'(RATE_DEN))
                          : acc_sum[ACC_W-1:0];
      end
      if (base_evt) begin
        bcnt_q <= bit_edge ? '0 : bcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sir_frame_ctrl.sv
module sir_frame_ctrl
  import sir_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic [BAUD_W-1:0] new_baud,
  input  logic [PW_W-1:0]   new_width,
  input  logic              bit_edge,
  output logic              byte_ready,
  output logic              accept,
  output logic              busy,
  output logic              zero_start,
  output logic [BAUD_W-1:0] baud_q,
  output logic [PW_W-1:0]   width_q
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  tx_state_t             state_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  at_last;
  logic                  last_edge;

  assign busy       = (state_q == ST_SEND);
  assign at_last    = (idx_q == LAST_IDX);
  assign last_edge  = busy && bit_edge && at_last;
  assign byte_ready = !busy || last_edge;
  assign accept     = byte_valid && byte_ready;
  // a pulse is launched for the start bit and for each later zero bit
  assign zero_start = accept || (busy && bit_edge && !at_last && !sh_q[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sh_q    <= '1;
      idx_q   <= '0;
      baud_q  <= '0;
      width_q <= '0;
    end else if (accept) begin
      state_q <= ST_SEND;
      sh_q    <= {1'b1, byte_data, 1'b0};
      idx_q   <= '0;
      baud_q  <= new_baud;
      width_q <= new_width;
    end else if (busy && bit_edge) begin
      if (at_last) begin
        state_q <= ST_IDLE;
      end else begin
        sh_q  <= {1'b1, sh_q[FRAME_BITS-1:1]};
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sir_pulse_shaper.sv
module sir_pulse_shaper
  import sir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bit_edge,
  input  logic             zero_start,
  input  logic [LEN_W-1:0] len,
  output logic             pulse
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      cnt_q <= '0;
    end else if (zero_start) begin
      pulse <= 1'b1;
      cnt_q <= len;
    end else if (bit_edge) begin
      pulse <= 1'b0;
    end else if (pulse && tick) begin
      if (cnt_q == LEN_W'(1)) pulse <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/sir_tx_modulator.sv
module sir_tx_modulator
  import sir_pkg::*;
#(
  parameter int CLK_DIV  = 5,
  parameter int RATE_NUM = 9,
  parameter int RATE_DEN = 625
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] phy_ctl,
  input  logic        tx_invert,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output logic        byte_ready,
  output logic        ir_out
);
  localparam int unsigned BASE_FLOOR = RATE_DEN / RATE_NUM;

  phy_word_t         pw;
  logic              tick, bit_edge, accept, busy, zero_start, pulse, inv_q;
  logic [BAUD_W-1:0] baud_q;
  logic [PW_W-1:0]   width_q;
  logic [LEN_W-1:0]  len;
  logic              unused_preamble;

  assign pw              = phy_word_t'(phy_ctl);
  assign unused_preamble = ^pw.pre;
  assign len = accept ? pulse_len(pw.baud, pw.width, BASE_FLOOR)
                      : pulse_len(baud_q, width_q, BASE_FLOOR);

  sir_frame_ctrl #(.DATA_W(8)) u_frame (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .new_baud(pw.baud), .new_width(pw.width), .bit_edge(bit_edge),
    .byte_ready(byte_ready), .accept(accept), .busy(busy),
    .zero_start(zero_start), .baud_q(baud_q), .width_q(width_q)
  );

  sir_tick_gen #(.CLK_DIV(CLK_DIV), .RATE_NUM(RATE_NUM), .RATE_DEN(RATE_DEN)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .baud(baud_q),
    .tick(tick), .bit_edge(bit_edge)
  );

  sir_pulse_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_edge(bit_edge),
    .zero_start(zero_start), .len(len), .pulse(pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) inv_q <= 1'b0;
    else        inv_q <= tx_invert;
  end

  assign ir_out = pulse ^ inv_q;
endmodule

// File: rtl/sir_tx_checker.sv
module sir_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       bit_edge,
  input logic       accept,
  input logic       busy,
  input logic       zero_start,
  input logic       pulse,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic       tx_invert,
  input logic       ir_out,
  input logic [5:0] baud_q
);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> pulse);
  p_idle_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pulse);
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  p_edge_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_edge |-> tick);
  p_rise_at_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(zero_start));
  p_ready_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_edge) |-> !byte_ready);
  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !byte_valid) |=> (ir_out == $past(tx_invert)));
  p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(baud_q));
endmodule

bind sir_tx_modulator sir_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bit_edge(bit_edge),
  .accept(accept), .busy(busy), .zero_start(zero_start), .pulse(pulse),
  .byte_valid(byte_valid), .byte_ready(byte_ready), .tx_invert(tx_invert),
  .ir_out(ir_out), .baud_q(baud_q)
);

// File: tb/sim_sir_tx_modulator.sv
`timescale 1ns/1ps
module sim_sir_tx_modulator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] phy_ctl = '0;
  logic        tx_invert = 1'b0;
  logic        byte_valid = 1'b0;
  logic [7:0]  byte_data = '0;
  wire         byte_ready;
  wire         ir_out;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sir_tx_modulator u0 (
    .clk(clk), .rst_n(rst_n), .phy_ctl(phy_ctl), .tx_invert(tx_invert),
    .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready), .ir_out(ir_out)
  );

  // clocks from the accepting edge to the start of bit k
  function automatic int edge_clk(int k, int b);
    return 5 * ((625 * k * (b + 1) + 8) / 9);
  endfunction

  function automatic logic exp_pulse(int n, logic [7:0] d0, logic [7:0] d1,
                                     int nfr, int b, int w);
    int wt = (w + 1) * (b + 1);
    for (int f = 0; f < nfr; f++) begin
      for (int i = 0; i < 10; i++) begin
        logic bv;
        int st;
        if (i == 0) bv = 1'b0;
        else if (i == 9) bv = 1'b1;
        else bv = (f == 0) ? d0[i-1] : d1[i-1];
        st = edge_clk(10 * f + i, b);
        if (!bv && n >= st && n < st + 5 * wt) return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  task automatic check(string req, logic ok, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", byte_ready === 1'b1, int'(byte_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", byte_ready === 1'b1, int'(byte_ready), 1);
    check("R1", ir_out === 1'b0, int'(ir_out), 0);
  endtask

  task automatic run_frames(string tag, logic [7:0] d0, logic [7:0] d1, int nfr,
                            int b, int w, int p, logic inv, bit mid_change);
    int wave_bad = 0, rdy_bad = 0, rises = 0, zeros = 0;
    int first_n = -1, first_act = 0, first_exp = 0;
    int endn;
    logic prev_act = 1'b0;
    phy_ctl    = {6'(b), 5'(w), 5'(p)};
    tx_invert  = inv;
    byte_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", ir_out === inv, int'(ir_out), int'(inv));
    check("R2", byte_ready === 1'b1, int'(byte_ready), 1);
    byte_data  = d0;
    byte_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (nfr == 2) byte_data = d1;
    else byte_valid = 1'b0;
    endn = edge_clk(10 * nfr, b) + 4;
    for (int n = 0; n <= endn; n++) begin
      logic e_ir, e_rdy, act;
      e_ir  = exp_pulse(n, d0, d1, nfr, b, w) ^ inv;
      e_rdy = (n + 1 == edge_clk(10, b)) || (nfr == 2 && n + 1 == edge_clk(20, b))
              || (n >= edge_clk(10 * nfr, b));
      if (ir_out !== e_ir) begin
        wave_bad++;
        if (first_n < 0) begin
          first_n = n; first_act = int'(ir_out); first_exp = int'(e_ir);
        end
      end
      if (byte_ready !== e_rdy) rdy_bad++;
      act = ir_out ^ inv;
      if (act && !prev_act) rises++;
      prev_act = act;
      if (nfr == 2 && n == edge_clk(10, b)) byte_valid = 1'b0;
      if (mid_change && n == 7) phy_ctl = {6'd5, 5'd31, 5'd9};
      @(negedge clk);
    end
    if (wave_bad != 0) $display("  first waveform miss at clock %0d", first_n);
    check(tag, wave_bad == 0, first_act, first_exp);
    check("R2", rdy_bad == 0, rdy_bad, 0);
    for (int f = 0; f < nfr; f++) begin
      logic [7:0] d = (f == 0) ? d0 : d1;
      zeros++;
      for (int i = 0; i < 8; i++) if (!d[i]) zeros++;
    end
    check("R3", rises == zeros, rises, zeros);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    run_frames("R5", 8'h55, 8'h00, 1, 0, 12, 0, 1'b0, 1'b0);
    run_frames("R5", 8'h00, 8'h00, 1, 1, 5, 0, 1'b0, 1'b0);
    run_frames("R6", 8'hFF, 8'h00, 1, 2, 3, 0, 1'b1, 1'b0);
    run_frames("R7", 8'hA3, 8'h00, 1, 5, 1, 31, 1'b0, 1'b0);
    run_frames("R8", 8'h3C, 8'h00, 1, 0, 11, 0, 1'b0, 1'b1);
    run_frames("R9", 8'h81, 8'h7E, 2, 0, 12, 0, 1'b0, 1'b0);
    run_frames("R4", 8'h0F, 8'h00, 1, 11, 0, 0, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule